// File: doc/BRIEF.md
# Chainable 16-bit Serial Command Slave

This block is a serial slave for a four-wire bus made of a serial clock, an active-low select, a data input and a data output. It does not use the serial clock as a clock. A faster system clock oversamples all three inputs through two-flop synchronizers, and edge detection runs on the synchronized levels. While select is low, one bit is shifted in on each rising serial-clock edge, most significant bit first. When select rises, a complete frame is decoded. Bit 15 is the operation (0 = write, 1 = read), bits 14..8 are a 7-bit register address and bits 7..0 are the data. The block drives a register bank with an address, write data, a one-cycle write strobe and a one-cycle read request.

Read data returned by the bank is written over the low byte of the shift register. The master collects it during the following frame. The data output is the shift register's top bit, updated on falling serial-clock edges. It therefore repeats the input stream 15.5 serial clocks later. Several slaves that share select and clock can be chained output-to-input, with 16 clocks per slave per access. Address 0 acts as a no-op, so one slave in the chain can be addressed while the others are left untouched. The system clock must run at least four times the serial-clock rate.

Top module: `spi_cmd_slave`

## Requirements
- R1: While select is high, serial-clock and data-input activity changes neither the shift register, nor the data output, nor any strobe.
- R2: Data input is sampled on rising serial-clock edges, most significant bit first. Frame bit 15 is the operation (0 write, 1 read), bits 14..8 are the address and bits 7..0 are the data.
- R3: A write frame with a nonzero address gives exactly one single-cycle reg_wr_o pulse, with reg_addr_o and reg_wdata_o taken from the frame. The pulse comes 3 system clocks after the select rise reaches the pins.
- R4: If more than 16 bits arrive in one select-low period, only the last 16 are decoded.
- R5: A frame with fewer than 16 rising serial-clock edges since select fell gives no strobe.
- R6: The data output takes the shift register's bit 15 on each falling serial-clock edge and when select falls. On rising edge k of a frame, the master sees the bit sampled 16 rising edges earlier in the stream. The output is never high-impedance.
- R7: A frame with address 0 (read or write) gives no strobe.
- R8: A read frame with a nonzero address gives one reg_rd_o pulse. The bank's reply in that cycle replaces shift-register bits 7..0, and the master sees it on rising edges 9..16 of the next frame.
- R9: A frame executes the same way whether select rises while the serial clock is still high after the last bit or after it has gone low.
- R10: With two slaves chained, a 32-clock access delivers the first 16 bits to the far slave and the last 16 bits to the near slave.
- R11: Reset clears the data output, the strobes and the address output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| cs_n_i | input | 1 | Active-low select (asynchronous) |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out, delayed stream or read reply |
| reg_addr_o | output | ADDR_W | Register address of the last executed frame |
| reg_wdata_o | output | DATA_W | Write data of the last executed frame |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read request |
| reg_rdata_i | input | DATA_W | Read data from the bank, valid while reg_rd_o is high |

## Verification
Every serial edge passes through two synchronizer flops and one output register. The data output therefore settles 3 system clocks after a serial-clock fall or select fall. The bench holds each serial phase for 4 system clocks and samples the output just before it drives each rising edge. The strobes fire 3 clocks after select rises, and the read reply is loaded one clock after that. The bench waits 12 clocks after select rises before it compares strobe counts, address and data, which a monitor records on every system clock. The expected output stream for every frame comes from a bench model of the shift register: the concatenation of the previous contents and the new bits, with the read reply computed arithmetically and inserted.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } cmd_op_e;

    localparam int unsigned SYNC_DEPTH_DFLT = 2;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int unsigned           WIDTH   = 3,
    parameter int unsigned           STAGES  = 2,
    parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign level_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_edge.sv
module spi_cmd_edge #(
    parameter int unsigned      WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < int'(WIDTH); g++) begin : g_edge
        assign rise_o[g] =  level_i[g] & ~prev_q[g];
        assign fall_o[g] = ~level_i[g] &  prev_q[g];
    end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_low_i,
    input  logic               cs_fall_i,
    input  logic               sclk_rise_i,
    input  logic               sclk_fall_i,
    input  logic               din_i,
    input  logic               load_i,
    input  logic [DATA_W-1:0]  load_data_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               full_o,
    output logic               dout_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               dout;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall_i) begin
            st_d.cnt  = '0;
            st_d.dout = st_q.sr[FRAME_W-1];
        end else if (cs_low_i) begin
            if (sclk_rise_i) begin
                st_d.sr = {st_q.sr[FRAME_W-2:0], din_i};
                if (st_q.cnt != CNT_FULL) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sclk_fall_i) st_d.dout = st_q.sr[FRAME_W-1];
        end
        if (load_i) st_d.sr[DATA_W-1:0] = load_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o = st_q.sr;
    assign full_o  = (st_q.cnt == CNT_FULL);
    assign dout_o  = st_q.dout;

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_low_i && !load_i) |=> $stable(st_q.sr));

    p_dout_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall_i && !cs_fall_i) |=> $stable(dout_o));
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_rise_i,
    input  logic                    full_i,
    input  logic [ADDR_W+DATA_W:0]  frame_i,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [DATA_W-1:0]       wdata_o,
    output logic                    wr_o,
    output logic                    rd_o
);
    localparam int unsigned FRAME_W = ADDR_W + DATA_W + 1;
    localparam int unsigned OP_BIT  = FRAME_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              rd;
    } dec_st_t;

    dec_st_t st_d, st_q;
    cmd_op_e op;
    logic [ADDR_W-1:0] fr_addr;
    logic exec;

    assign op      = cmd_op_e'(frame_i[OP_BIT]);
    assign fr_addr = frame_i[OP_BIT-1 -: ADDR_W];
    assign exec    = cs_rise_i && full_i && (fr_addr != '0);

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        st_d.rd = 1'b0;
        if (exec) begin
            st_d.addr = fr_addr;
            if (op == OP_WR) begin
                st_d.wdata = frame_i[DATA_W-1:0];
                st_d.wr    = 1'b1;
            end else begin
                st_d.rd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.wdata;
    assign wr_o    = st_q.wr;
    assign rd_o    = st_q.rd;

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_o, rd_o}));

    p_strobe_needs_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o || rd_o) |-> $past(cs_rise_i && full_i));

    p_no_strobe_addr0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o || rd_o) |-> (addr_o != '0));

    p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o || rd_o) |=> !(wr_o || rd_o));
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DFLT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int unsigned FRAME_W = ADDR_W + DATA_W + 1;
    localparam int unsigned IX_SCLK = 0;
    localparam int unsigned IX_CSN  = 1;
    localparam int unsigned IX_DIN  = 2;

    logic [2:0] lvl;
    logic [1:0] rise, fall;
    logic [FRAME_W-1:0] frame;
    logic full;

    spi_cmd_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({din_i, cs_n_i, sclk_i}),
        .level_o (lvl)
    );

    spi_cmd_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (lvl[1:0]),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    spi_cmd_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_low_i    (~lvl[IX_CSN]),
        .cs_fall_i   (fall[IX_CSN]),
        .sclk_rise_i (rise[IX_SCLK]),
        .sclk_fall_i (fall[IX_SCLK]),
        .din_i       (lvl[IX_DIN]),
        .load_i      (reg_rd_o),
        .load_data_i (reg_rdata_i),
        .frame_o     (frame),
        .full_o      (full),
        .dout_o      (dout_o)
    );

    spi_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_rise_i (rise[IX_CSN]),
        .full_i    (full),
        .frame_i   (frame),
        .addr_o    (reg_addr_o),
        .wdata_o   (reg_wdata_o),
        .wr_o      (reg_wr_o),
        .rd_o      (reg_rd_o)
    );
endmodule

// File: tb/test_spi_cmd_slave.sv
module test_spi_cmd_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
    logic dout_a, dout_b;
    logic [6:0] addr_a, addr_b;
    logic [7:0] wdata_a, wdata_b, rdata_a, rdata_b;
    logic wr_a, rd_a, wr_b, rd_b;

    logic [7:0] mem_a [128];
    logic [7:0] mem_b [128];
    logic [7:0] exp_mem [128];
    int wr_cnt_a = 0, rd_cnt_a = 0, wr_cnt_b = 0;
    logic [6:0] wr_addr_seen, rd_addr_seen, wr_addr_b_seen;
    logic [7:0] wr_data_seen, wr_data_b_seen;
    logic [15:0] sr_model = '0;
    logic [31:0] last_sb;
    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    assign rdata_a = mem_a[addr_a];
    assign rdata_b = mem_b[addr_b];

    spi_cmd_slave i_spi_cmd_slave (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
        .dout_o(dout_a), .reg_addr_o(addr_a), .reg_wdata_o(wdata_a),
        .reg_wr_o(wr_a), .reg_rd_o(rd_a), .reg_rdata_i(rdata_a));

    spi_cmd_slave i_spi_cmd_slave_b (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(dout_a),
        .dout_o(dout_b), .reg_addr_o(addr_b), .reg_wdata_o(wdata_b),
        .reg_wr_o(wr_b), .reg_rd_o(rd_b), .reg_rdata_i(rdata_b));

    initial for (int i = 0; i < 128; i++) begin
        mem_a[i] = '0; mem_b[i] = '0; exp_mem[i] = '0;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_a) begin
                wr_cnt_a <= wr_cnt_a + 1; wr_addr_seen <= addr_a;
                wr_data_seen <= wdata_a; mem_a[addr_a] <= wdata_a;
            end
            if (rd_a) begin rd_cnt_a <= rd_cnt_a + 1; rd_addr_seen <= addr_a; end
            if (wr_b) begin
                wr_cnt_b <= wr_cnt_b + 1; wr_addr_b_seen <= addr_b;
                wr_data_b_seen <= wdata_b; mem_b[addr_b] <= wdata_b;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_frame(input int n, input logic [31:0] bits, input bit cs_early,
                            input string tag);
        logic [47:0] v;
        logic [31:0] mask, exp_seen, sa, sb;
        logic [15:0] last;
        int wr0, rd0;
        bit exp_wr, exp_rd;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        v = ({32'd0, sr_model} << n) | {16'd0, bits & mask};
        exp_seen = 32'(v >> 16) & mask;
        last = v[15:0];
        wr0 = wr_cnt_a; rd0 = rd_cnt_a;
        sa = '0; sb = '0;
        cs_n = 1'b0;
        tick(2);
        for (int i = n - 1; i >= 0; i--) begin
            din = bits[i];
            tick(4);
            sa = {sa[30:0], dout_a};
            sb = {sb[30:0], dout_b};
            sclk = 1'b1;
            tick(4);
            if (i == 0 && cs_early) begin cs_n = 1'b1; tick(1); end
            sclk = 1'b0;
        end
        cs_n = 1'b1;
        tick(12);
        last_sb = sb;
        // R6 / R8: output stream equals the shift-register model
        check((sa & mask) == exp_seen, {"R6 stream ", tag}, sa & mask, exp_seen);
        sr_model = last;
        exp_wr = (n >= 16) && (last[14:8] != 7'd0) && !last[15];
        exp_rd = (n >= 16) && (last[14:8] != 7'd0) &&  last[15];
        check(wr_cnt_a == wr0 + (exp_wr ? 1 : 0), {"R3 wr count ", tag},
              32'(wr_cnt_a - wr0), exp_wr ? 1 : 0);
        check(rd_cnt_a == rd0 + (exp_rd ? 1 : 0), {"R8 rd count ", tag},
              32'(rd_cnt_a - rd0), exp_rd ? 1 : 0);
        if (exp_wr) begin
            check({wr_addr_seen, wr_data_seen} == last[14:0], {"R2 wr fields ", tag},
                  {17'd0, wr_addr_seen, wr_data_seen}, {17'd0, last[14:0]});
            exp_mem[last[14:8]] = last[7:0];
        end
        if (exp_rd) begin
            check(rd_addr_seen == last[14:8], {"R8 rd addr ", tag},
                  {25'd0, rd_addr_seen}, {25'd0, last[14:8]});
            sr_model[7:0] = exp_mem[last[14:8]];
        end
    endtask

    initial begin
        tick(5);
        // R11 reset state
        check(dout_a == 1'b0, "R11 dout", {31'd0, dout_a}, 0);
        check(!wr_a && !rd_a, "R11 strobes", {30'd0, wr_a, rd_a}, 0);
        check(addr_a == 7'd0, "R11 addr", {25'd0, addr_a}, 0);
        rst_n = 1'b1;
        tick(5);

        // R3 write sweep over every nonzero address
        for (int a = 1; a < 128; a++)
            do_frame(16, {16'd0, 1'b0, 7'(a), 8'((a * 37 + 11) & 255)}, 1'b0, "R3 sweep");
        // R8 read sweep; reply checked on the following frame's stream
        for (int a = 1; a < 128; a++)
            do_frame(16, {16'd0, 1'b1, 7'(a), 8'h5A}, 1'b0, "R8 sweep");
        do_frame(16, 32'h0000, 1'b0, "R7 noop write");
        do_frame(16, 32'h80AB, 1'b0, "R7 read addr0");

        // R1 activity with select high
        begin
            logic d0;
            int w0, r0;
            d0 = dout_a; w0 = wr_cnt_a; r0 = rd_cnt_a;
            for (int i = 0; i < 20; i++) begin
                din = i[0]; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
            end
            tick(12);
            check(dout_a == d0, "R1 dout held", {31'd0, dout_a}, {31'd0, d0});
            check(wr_cnt_a == w0 && rd_cnt_a == r0, "R1 no strobe",
                  32'(wr_cnt_a + rd_cnt_a), 32'(w0 + r0));
        end
        do_frame(16, 32'h0000, 1'b0, "R1 sr unchanged");

        do_frame(10, 32'h2A5, 1'b0, "R5 short");
        do_frame(7, 32'h45, 1'b0, "R5 short");
        do_frame(20, 32'hA09C3, 1'b0, "R4 long write");
        do_frame(24, 32'hFF_8900, 1'b0, "R4 long read");
        do_frame(16, {16'd0, 1'b0, 7'h33, 8'h5E}, 1'b1, "R9 early cs write");
        do_frame(16, {16'd0, 1'b1, 7'h33, 8'h00}, 1'b1, "R9 early cs read");
        do_frame(16, {16'd0, 1'b1, 7'h05, 8'h00}, 1'b0, "R5 addr5 intact");
        do_frame(16, 32'h0000, 1'b0, "R8 flush");

        // R10 two-device chain
        begin
            int wb0;
            wb0 = wr_cnt_b;
            do_frame(32, {1'b0, 7'h44, 8'h96, 16'h0000}, 1'b0, "R10 chain write");
            check(wr_cnt_b == wb0 + 1, "R10 far count", 32'(wr_cnt_b - wb0), 1);
            check({wr_addr_b_seen, wr_data_b_seen} == {7'h44, 8'h96}, "R10 far fields",
                  {17'd0, wr_addr_b_seen, wr_data_b_seen}, {17'd0, 7'h44, 8'h96});
            do_frame(32, {1'b1, 7'h44, 8'h00, 16'h0000}, 1'b0, "R10 chain read");
            do_frame(32, 32'h0, 1'b0, "R10 chain flush");
            check(last_sb[23:16] == 8'h96, "R10 far reply", {24'd0, last_sb[23:16]}, 32'h96);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule